// File: doc/BRIEF.md
# Interlaced Display Status Word

This block holds the 32-bit status word of an interlaced video display engine. A display timing source feeds it one-cycle strobes when field 1 or field 2 has been fully shown, a level that is high during vertical blanking, the field that comes next, and the current line and pixel indices. The block turns the completion strobes into sticky flags, and software clears each flag by writing a 1 to its bit. It also keeps a registered copy of the blanking level, the active field and the two position indices.

The register bus has no address, because there is only one word. The read data always shows the current word. A write strobe with a data word clears the flags whose bits are 1 in that word. Every other bit in a write is ignored. The active-field bit changes at only one point: the cycle in which blanking begins. At that point it takes the upcoming-field value that the timing source supplies.

Top module: `vid_status_reg`

## Requirements
- R1: While reset is asserted, and right after it, the whole read word is 0.
- R2: A pulse on the field-1-done input sets bit 28. The bit stays 1 on later cycles until software clears it.
- R3: A pulse on the field-2-done input sets bit 29 (field 2 shown) and bit 30 (frame shown) in the same cycle. Both bits are sticky.
- R4: A write with a 1 in bit 28, 29 or 30 clears that flag on the next cycle. A 0 in any of those bits leaves the flag as it was.
- R5: If a completion pulse and a write-1 clear of the same flag arrive in the same cycle, the flag reads 1 afterwards.
- R6: Bits 27:16 show the 12-bit line index that was presented one cycle earlier.
- R7: Bits 11:0 show the 12-bit pixel index that was presented one cycle earlier.
- R8: Bit 13 shows the blanking input as it was one cycle earlier (1 means in blanking).
- R9: Bit 12 shows the active field (0 = field 1, 1 = field 2). It loads the upcoming-field input only in the cycle where the blanking input goes from 0 to 1. At all other times it holds its value.
- R10: Bits 31, 15 and 14 always read 0. Writes have no effect on any bit except the three flag clears of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld1_done_i | input | 1 | One-cycle strobe: field 1 fully shown |
| fld2_done_i | input | 1 | One-cycle strobe: field 2 fully shown |
| vblank_i | input | 1 | High during vertical blanking |
| next_field_i | input | 1 | Field that follows (0 = field 1, 1 = field 2) |
| line_idx_i | input | 12 | Current line index within the field |
| pix_idx_i | input | 12 | Index of the pixel most recently output |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data (1s clear flags) |
| bus_rdata_o | output | 32 | Status word |

## Verification
A reference model in the bench predicts every bit of the word on each clock. The directed patterns come first. Isolated completion pulses show that the flags are sticky and that field 2 also sets the frame flag. Clears written with 0s and with 1s show which writes have an effect, and a clear landing on a pulse shows that the set wins. Blanking edges with the upcoming-field input changing both inside and outside those edges show that the field bit loads only on a rising edge. An all-ones write shows that the reserved bits and the index bits cannot be written. A long random phase then mixes every input so that rare overlaps of these events occur too.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int WORD_W   = 32;
  localparam int POS_W    = 12;
  localparam int N_FLAGS  = 3;
  localparam int FLAG_LSB = 28;   // f1 at 28, f2 at 29, frame at 30
  localparam int LINE_LSB = 16;
  localparam int VB_BIT   = 13;
  localparam int FLD_BIT  = 12;
  localparam int PIX_LSB  = 0;

  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [N_FLAGS-1:0] flags,
    input logic [POS_W-1:0]   line,
    input logic               vb,
    input logic               fld,
    input logic [POS_W-1:0]   pix);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FLAG_LSB +: N_FLAGS] = flags;
    w[LINE_LSB +: POS_W]   = line;
    w[VB_BIT]              = vb;
    w[FLD_BIT]             = fld;
    w[PIX_LSB +: POS_W]    = pix;
    return w;
  endfunction
endpackage

// File: rtl/vsr_sticky_flag.sv
module vsr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= vsr_pkg::sticky_next(q_o, set_i, clr_i);
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/vsr_field_track.sv
module vsr_field_track (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_i,
  input  logic next_field_i,
  output logic vblank_q_o,
  output logic field_o,
  output logic blank_rise_o
);
  assign blank_rise_o = vsr_pkg::rise_of(vblank_i, vblank_q_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank_q_o <= 1'b0;
      field_o    <= 1'b0;
    end else begin
      vblank_q_o <= vblank_i;
      if (blank_rise_o) field_o <= next_field_i;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_rise_o |=> $stable(field_o));
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    blank_rise_o |=> (field_o == $past(next_field_i)));
  a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank_rise_o |=> vblank_q_o);
endmodule

// File: rtl/vsr_pos_capture.sv
module vsr_pos_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/vid_status_reg.sv
module vid_status_reg
  import vsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fld1_done_i,
  input  logic              fld2_done_i,
  input  logic              vblank_i,
  input  logic              next_field_i,
  input  logic [POS_W-1:0]  line_idx_i,
  input  logic [POS_W-1:0]  pix_idx_i,
  input  logic              bus_wr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o
);
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic [POS_W-1:0]   line_q, pix_q;
  logic               vb_q, fld_q, blank_rise;

  // index 0: field 1, index 1: field 2, index 2: whole frame
  assign flag_set = {fld2_done_i, fld2_done_i, fld1_done_i};

  for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
    assign flag_clr[k] = bus_wr_i & bus_wdata_i[FLAG_LSB + k];
    vsr_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[k]),
      .clr_i (flag_clr[k]),
      .q_o   (flag_q[k])
    );
  end

  vsr_field_track u_fld (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_i     (vblank_i),
    .next_field_i (next_field_i),
    .vblank_q_o   (vb_q),
    .field_o      (fld_q),
    .blank_rise_o (blank_rise)
  );

  vsr_pos_capture #(.W(POS_W)) u_line (
    .clk (clk), .rst_n (rst_n), .d_i (line_idx_i), .q_o (line_q));
  vsr_pos_capture #(.W(POS_W)) u_pix (
    .clk (clk), .rst_n (rst_n), .d_i (pix_idx_i), .q_o (pix_q));

  assign bus_rdata_o = pack_word(flag_q, line_q, vb_q, fld_q, pix_q);

  a_r3_frame_with_f2: assert property (@(posedge clk) disable iff (!rst_n)
    fld2_done_i |=> (bus_rdata_o[30] && bus_rdata_o[29]));
  a_r6_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_rdata_o[27:16] == $past(line_idx_i)));
  a_r7_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_rdata_o[11:0] == $past(pix_idx_i)));
  a_r8_vblank: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_rdata_o[13] == $past(vblank_i)));
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !fld1_done_i && !fld2_done_i && bus_wdata_i[30:28] == 3'b000)
      |=> (bus_rdata_o[30:28] == $past(bus_rdata_o[30:28])));
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (bus_rdata_o == '0));
endmodule

// File: tb/vid_status_reg_bench.sv
module vid_status_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f1 = 0, f2 = 0, vb = 0, nf = 0, wr = 0;
  logic [11:0] line = 0, pix = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  string ctx = "";

  // behavioural reference state
  bit m_f1, m_f2, m_fr, m_vb, m_fld;
  int m_line, m_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_status_reg u_vid_status_reg (
    .clk (clk), .rst_n (rst_n),
    .fld1_done_i (f1), .fld2_done_i (f2), .vblank_i (vb), .next_field_i (nf),
    .line_idx_i (line), .pix_idx_i (pix),
    .bus_wr_i (wr), .bus_wdata_i (wdata), .bus_rdata_o (rdata));

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, ctx, $time, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R2 field1 flag", int'(rdata[28]), int'(m_f1));
    cmp("R3 field2 flag", int'(rdata[29]), int'(m_f2));
    cmp("R3 frame flag",  int'(rdata[30]), int'(m_fr));
    cmp("R6 line",        int'(rdata[27:16]), m_line);
    cmp("R7 pixel",       int'(rdata[11:0]), m_pix);
    cmp("R8 vblank",      int'(rdata[13]), int'(m_vb));
    cmp("R9 field",       int'(rdata[12]), int'(m_fld));
    cmp("R10 reserved",   int'({rdata[31], rdata[15:14]}), 0);
  endtask

  // one clock: check at negedge, drive, advance reference to post-edge state
  task automatic step(input bit i_f1, input bit i_f2, input bit i_vb, input bit i_nf,
                      input int i_line, input int i_pix, input bit i_wr, input bit [31:0] i_wd);
    @(negedge clk);
    check_all();
    f1 = i_f1; f2 = i_f2; vb = i_vb; nf = i_nf;
    line = 12'(i_line); pix = 12'(i_pix); wr = i_wr; wdata = i_wd;
    // R5: a set overrides a clear; R4: clear only on 1
    if (i_f1) m_f1 = 1; else if (i_wr && i_wd[28]) m_f1 = 0;
    if (i_f2) m_f2 = 1; else if (i_wr && i_wd[29]) m_f2 = 0;
    if (i_f2) m_fr = 1; else if (i_wr && i_wd[30]) m_fr = 0;
    if (i_vb && !m_vb) m_fld = i_nf;
    m_vb = i_vb;
    m_line = i_line;
    m_pix = i_pix;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    ctx = "R1 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 word in reset", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 word after reset", int'(rdata), 0);

    ctx = "R2 sticky f1";
    step(1,0,0,0, 10,20, 0,0);
    repeat (4) step(0,0,0,0, 11,21, 0,0);
    ctx = "R4 write zeros";
    step(0,0,0,0, 12,22, 1,32'h0);
    step(0,0,0,0, 12,22, 1,32'h8FFF_FFFF);
    ctx = "R3 f2 and frame";
    step(0,1,0,0, 13,23, 0,0);
    repeat (3) step(0,0,0,0, 13,23, 0,0);
    ctx = "R4 clear f1 only";
    step(0,0,0,0, 14,24, 1,32'h1000_0000);
    step(0,0,0,0, 14,24, 0,0);
    ctx = "R4 clear frame only";
    step(0,0,0,0, 14,24, 1,32'h4000_0000);
    step(0,0,0,0, 14,24, 0,0);
    ctx = "R5 set beats clear";
    step(1,1,0,0, 15,25, 1,32'h7000_0000);
    step(0,0,0,0, 15,25, 0,0);
    step(0,0,0,0, 15,25, 1,32'h7000_0000);
    step(0,0,0,0, 15,25, 0,0);
    ctx = "R9 field load on rise";
    step(0,0,0,1, 16,26, 0,0);
    step(0,0,1,1, 16,26, 0,0);
    step(0,0,1,0, 16,26, 0,0);
    step(0,0,1,0, 16,26, 0,0);
    step(0,0,0,0, 16,26, 0,0);
    step(0,0,0,1, 16,26, 0,0);
    step(0,0,1,0, 16,26, 0,0);
    step(0,0,0,1, 16,26, 0,0);
    ctx = "R10 all-ones write";
    step(0,0,0,0, 12'hABC,12'h123, 1,32'hFFFF_FFFF);
    step(0,0,0,0, 12'hFFF,12'hFFF, 1,32'h8000_C000);
    step(0,0,0,0, 0,0, 0,0);

    ctx = "random mix R2-R10";
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0,9) == 0), ($urandom_range(0,9) == 0),
           ($urandom_range(0,3) != 0) ? vb : ~vb, 1'($urandom),
           int'($urandom_range(0,4095)), int'($urandom_range(0,4095)),
           ($urandom_range(0,4) == 0), $urandom);
    end
    @(negedge clk);
    check_all();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule